// File: doc/BRIEF.md
# Microprogrammed Multicycle Control Unit

This block steers a multicycle processor datapath built around one memory, one register file and one ALU. A 4-bit micro-program counter selects a word from an internal microcode store. Each 14-bit microword is vertically encoded into short fields. A local decoder expands those fields into the individual datapath strobes and selects. A separate opcode table picks the first micro-step of each instruction after the shared two-step fetch/decode prologue.

Sequencing is not a hand-built state graph. Every microword carries a 2-bit sequencing code that chooses between three targets: jump back to fetch, take the opcode dispatch, or advance by one. The supported instruction classes are register-register ALU operations, OR-immediate, load word, store word and branch-on-equal. Each class runs its own short micro-sequence and then returns to fetch.

Micro-steps, which are the states of the enumerated micro-program counter: `US_FETCH` (0), `US_DECODE` (1), `US_RR_EXEC` (2), `US_RR_WB` (3), `US_ORI_EXEC` (4), `US_ORI_WB` (5), `US_LD_ADDR` (6), `US_LD_READ` (7), `US_LD_WB` (8), `US_ST_ADDR` (9), `US_ST_WRITE` (10), `US_BR_CMP` (11).

Transitions:
- `US_FETCH` goes to `US_DECODE` by increment.
- `US_DECODE` goes to the dispatch target.
- Each EXEC, ADDR or READ step goes to the following step by increment.
- Each WB step, `US_ST_WRITE` and `US_BR_CMP` go back to `US_FETCH`.
- Reset forces `US_FETCH`.

Top module: `mcu_ctrl`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, places the micro-program counter at 0 (`upc`=0) at that edge. Reset also overrides sequencing in the middle of an instruction.
- R2: The sequencing field is decoded as follows. Code 00 sends the counter to 0. Code 01 loads the dispatch target. Code 10 loads the current address plus one. Code 11 behaves like 00. The counter advances on every rising edge.
- R3: The dispatch table maps each opcode to a start address. Opcode 0x00 maps to 2, 0x0D to 4, 0x23 to 6, 0x2B to 9 and 0x04 to 11. Any other opcode maps to 0, so an unknown instruction returns to fetch two cycles after fetch.
- R4: Fetch step 0 drives an add of PC and constant 4, a memory read at the PC, an instruction register write and an unconditional PC write, then increments. Decode step 1 drives an add of PC and the shifted sign-extended immediate, with no strobes, then dispatches.
- R5: Destination decode, shown as {reg_wr, mem_to_reg, reg_dst}. None gives 000. ALU result to rd gives 101. ALU result to rt gives 100. Memory data to rt gives 110.
- R6: Memory decode, shown as {mem_rd, mem_wr, addr_sel}. None gives 000. Read at PC gives 100. Read at ALUout gives 101. Write at ALUout gives 011. `mem_rd` and `mem_wr` are never high together.
- R7: Operand decode. `alu_sel_a` is 0 for PC and 1 for Reg[rs]. `alu_sel_b` is 00 for constant 4, 01 for the immediate, 10 for the immediate shifted left by two and 11 for Reg[rt]. `ext_sign` is 1 for sign extension, and is 0 only when the zero-extended immediate is selected.
- R8: With the PC-write field set, a step whose ALU code is not subtract raises `pc_wr` with `pc_src`=0 (live ALU result). A step whose ALU code is subtract raises `pc_src`=1 (ALUout) and raises `pc_wr` only while `alu_zero` is 1.
- R9: Including fetch and decode, a full instruction takes a fixed number of cycles before `upc` is 0 again: R-type 4, ori 4, lw 5, sw 4, beq 3.
- R10: `alu_op` encoding: 00 add, 01 subtract, 10 function code, 11 OR. R-type executes with function code on rs and rt, ori with OR on rs and the zero-extended immediate, lw and sw addresses with add on rs and the sign-extended immediate, and beq with subtract on rs and rt. Steps that use no ALU leave the ALU and operand fields at zero (add, PC, constant 4, sign mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| alu_op | output | 2 | ALU operation code |
| alu_sel_a | output | 1 | First operand: 0 PC, 1 Reg[rs] |
| alu_sel_b | output | 2 | Second operand select |
| ext_sign | output | 1 | Immediate extender: 1 sign, 0 zero |
| reg_wr | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Write data: 0 ALUout, 1 memory data |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUout |
| ir_wr | output | 1 | Instruction register write |
| pc_wr | output | 1 | Effective PC load enable |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALUout |
| upc | output | 4 | Current micro-address |

## Verification
All control outputs decode combinationally from the current micro-address and `alu_zero`, so they are valid in the same cycle the address is, and each new address appears one rising edge after the step that chose it. The bench changes inputs and samples outputs only at falling edges. After each rising edge it checks the complete output vector of the step just entered. The return to address 0 is therefore checked exactly one edge after the last step of each sequence. A reset check samples at the first falling edge after a rising edge that saw reset high, including a reset raised mid-instruction.

// File: rtl/mcu_ctrl_pkg.sv
package mcu_ctrl_pkg;

    localparam int OPC_W = 6;
    localparam int UA_W  = 4;

    typedef enum logic [UA_W-1:0] {
        US_FETCH    = 4'd0,
        US_DECODE   = 4'd1,
        US_RR_EXEC  = 4'd2,
        US_RR_WB    = 4'd3,
        US_ORI_EXEC = 4'd4,
        US_ORI_WB   = 4'd5,
        US_LD_ADDR  = 4'd6,
        US_LD_READ  = 4'd7,
        US_LD_WB    = 4'd8,
        US_ST_ADDR  = 4'd9,
        US_ST_WRITE = 4'd10,
        US_BR_CMP   = 4'd11
    } ustate_t;

    typedef enum logic [1:0] {
        SQ_FETCH = 2'b00,
        SQ_DISP  = 2'b01,
        SQ_INC   = 2'b10,
        SQ_RSVD  = 2'b11
    } seq_t;

    typedef enum logic [1:0] {
        AL_ADD = 2'b00,
        AL_SUB = 2'b01,
        AL_FN  = 2'b10,
        AL_OR  = 2'b11
    } alu_t;

    typedef enum logic [2:0] {
        B_FOUR = 3'b000,
        B_SEXT = 3'b001,
        B_ZEXT = 3'b010,
        B_SHFT = 3'b011,
        B_RT   = 3'b100
    } srcb_t;

    typedef enum logic [1:0] {
        D_NONE  = 2'b00,
        D_RD_AL = 2'b01,
        D_RT_AL = 2'b10,
        D_RT_MM = 2'b11
    } dest_t;

    typedef enum logic [1:0] {
        M_NONE = 2'b00,
        M_RDPC = 2'b01,
        M_RDAL = 2'b10,
        M_WRAL = 2'b11
    } mem_t;

    // 14-bit vertically encoded microword
    typedef struct packed {
        alu_t  alu;
        logic  src_a;
        srcb_t src_b;
        dest_t dest;
        mem_t  mem;
        logic  irw;
        logic  pcw;
        seq_t  seq;
    } uword_t;

    localparam int UW_W = $bits(uword_t);

    localparam logic [OPC_W-1:0] OP_RR  = 6'h00;
    localparam logic [OPC_W-1:0] OP_ORI = 6'h0D;
    localparam logic [OPC_W-1:0] OP_LW  = 6'h23;
    localparam logic [OPC_W-1:0] OP_SW  = 6'h2B;
    localparam logic [OPC_W-1:0] OP_BEQ = 6'h04;

endpackage

// File: rtl/mcu_dispatch.sv
module mcu_dispatch
    import mcu_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ustate_t          target
);

    always_comb begin
        unique case (opcode)
            OP_RR:   target = US_RR_EXEC;
            OP_ORI:  target = US_ORI_EXEC;
            OP_LW:   target = US_LD_ADDR;
            OP_SW:   target = US_ST_ADDR;
            OP_BEQ:  target = US_BR_CMP;
            default: target = US_FETCH;
        endcase
    end

endmodule

// File: rtl/mcu_useq.sv
module mcu_useq
    import mcu_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  seq_t    seq,
    input  ustate_t disp,
    output ustate_t upc_q
);

    ustate_t upc_d;

    always_comb begin
        unique case (seq)
            SQ_DISP: upc_d = disp;
            SQ_INC:  upc_d = ustate_t'(4'(upc_q) + 4'd1);
            default: upc_d = US_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) upc_q <= US_FETCH;
        else     upc_q <= upc_d;
    end

    // R1
    a_r1_reset_to_fetch: assert property (@(posedge clk) rst |=> upc_q == US_FETCH);
    // R2
    a_r2_seq_increment: assert property (@(posedge clk) disable iff (rst)
        seq == SQ_INC |=> 4'(upc_q) == 4'($past(upc_q) + 4'd1));
    // R2
    a_r2_seq_fetch: assert property (@(posedge clk) disable iff (rst)
        (seq == SQ_FETCH || seq == SQ_RSVD) |=> upc_q == US_FETCH);
    // R2
    a_r2_seq_dispatch: assert property (@(posedge clk) disable iff (rst)
        seq == SQ_DISP |=> upc_q == $past(disp));

endmodule

// File: rtl/mcu_ucode.sv
module mcu_ucode
    import mcu_ctrl_pkg::*;
(
    input  ustate_t upc,
    output uword_t  uw
);

    always_comb begin
        uw = '0;
        unique case (upc)
            US_FETCH: begin
                uw.mem = M_RDPC;
                uw.irw = 1'b1;
                uw.pcw = 1'b1;
                uw.seq = SQ_INC;
            end
            US_DECODE: begin
                uw.src_b = B_SHFT;
                uw.seq   = SQ_DISP;
            end
            US_RR_EXEC: begin
                uw.alu   = AL_FN;
                uw.src_a = 1'b1;
                uw.src_b = B_RT;
                uw.seq   = SQ_INC;
            end
            US_RR_WB:  uw.dest = D_RD_AL;
            US_ORI_EXEC: begin
                uw.alu   = AL_OR;
                uw.src_a = 1'b1;
                uw.src_b = B_ZEXT;
                uw.seq   = SQ_INC;
            end
            US_ORI_WB: uw.dest = D_RT_AL;
            US_LD_ADDR, US_ST_ADDR: begin
                uw.src_a = 1'b1;
                uw.src_b = B_SEXT;
                uw.seq   = SQ_INC;
            end
            US_LD_READ: begin
                uw.mem = M_RDAL;
                uw.seq = SQ_INC;
            end
            US_LD_WB:    uw.dest = D_RT_MM;
            US_ST_WRITE: uw.mem  = M_WRAL;
            US_BR_CMP: begin
                uw.alu   = AL_SUB;
                uw.src_a = 1'b1;
                uw.src_b = B_RT;
                uw.pcw   = 1'b1;
            end
            default: uw = '0;
        endcase
    end

endmodule

// File: rtl/mcu_field_dec.sv
module mcu_field_dec
    import mcu_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  uword_t     uw,
    input  logic       alu_zero,
    output logic [1:0] alu_op,
    output logic       alu_sel_a,
    output logic [1:0] alu_sel_b,
    output logic       ext_sign,
    output logic       reg_wr,
    output logic       mem_to_reg,
    output logic       reg_dst,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       addr_sel,
    output logic       ir_wr,
    output logic       pc_wr,
    output logic       pc_src
);

    logic is_branch;

    assign alu_op    = uw.alu;
    assign alu_sel_a = uw.src_a;
    assign ir_wr     = uw.irw;
    assign is_branch = (uw.alu == AL_SUB);

    always_comb begin
        unique case (uw.src_b)
            B_SEXT:  begin alu_sel_b = 2'b01; ext_sign = 1'b1; end
            B_ZEXT:  begin alu_sel_b = 2'b01; ext_sign = 1'b0; end
            B_SHFT:  begin alu_sel_b = 2'b10; ext_sign = 1'b1; end
            B_RT:    begin alu_sel_b = 2'b11; ext_sign = 1'b1; end
            default: begin alu_sel_b = 2'b00; ext_sign = 1'b1; end
        endcase
    end

    always_comb begin
        unique case (uw.dest)
            D_RD_AL: {reg_wr, mem_to_reg, reg_dst} = 3'b101;
            D_RT_AL: {reg_wr, mem_to_reg, reg_dst} = 3'b100;
            D_RT_MM: {reg_wr, mem_to_reg, reg_dst} = 3'b110;
            default: {reg_wr, mem_to_reg, reg_dst} = 3'b000;
        endcase
    end

    always_comb begin
        unique case (uw.mem)
            M_RDPC:  {mem_rd, mem_wr, addr_sel} = 3'b100;
            M_RDAL:  {mem_rd, mem_wr, addr_sel} = 3'b101;
            M_WRAL:  {mem_rd, mem_wr, addr_sel} = 3'b011;
            default: {mem_rd, mem_wr, addr_sel} = 3'b000;
        endcase
    end

    always_comb begin
        pc_src = uw.pcw & is_branch;
        pc_wr  = uw.pcw & (~is_branch | alu_zero);
    end

    // R6
    a_r6_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R8
    a_r8_cond_needs_zero: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src) |-> alu_zero);
    // R5
    a_r5_memdata_writes: assert property (@(posedge clk) disable iff (rst)
        mem_to_reg |-> (reg_wr && !reg_dst));
    // R4
    a_r4_irwr_with_fetch: assert property (@(posedge clk) disable iff (rst)
        ir_wr |-> (mem_rd && !addr_sel && pc_wr && !pc_src));

endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
    import mcu_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output logic [1:0]       alu_op,
    output logic             alu_sel_a,
    output logic [1:0]       alu_sel_b,
    output logic             ext_sign,
    output logic             reg_wr,
    output logic             mem_to_reg,
    output logic             reg_dst,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_sel,
    output logic             ir_wr,
    output logic             pc_wr,
    output logic             pc_src,
    output logic [UA_W-1:0]  upc
);

    ustate_t upc_q;
    ustate_t disp;
    uword_t  uw;

    mcu_dispatch u_disp (
        .opcode (opcode),
        .target (disp)
    );

    mcu_useq u_seq (
        .clk   (clk),
        .rst   (rst),
        .seq   (uw.seq),
        .disp  (disp),
        .upc_q (upc_q)
    );

    mcu_ucode u_rom (
        .upc (upc_q),
        .uw  (uw)
    );

    mcu_field_dec u_dec (
        .clk        (clk),
        .rst        (rst),
        .uw         (uw),
        .alu_zero   (alu_zero),
        .alu_op     (alu_op),
        .alu_sel_a  (alu_sel_a),
        .alu_sel_b  (alu_sel_b),
        .ext_sign   (ext_sign),
        .reg_wr     (reg_wr),
        .mem_to_reg (mem_to_reg),
        .reg_dst    (reg_dst),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .addr_sel   (addr_sel),
        .ir_wr      (ir_wr),
        .pc_wr      (pc_wr),
        .pc_src     (pc_src)
    );

    assign upc = upc_q;

    // R3
    a_r3_unknown_refetch: assert property (@(posedge clk) disable iff (rst)
        (upc_q == US_DECODE && disp == US_FETCH) |=> upc_q == US_FETCH);

endmodule

// File: tb/mcu_ctrl_tb.sv
`timescale 1ns/1ps
module mcu_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic [1:0] alu_op, alu_sel_b;
    logic       alu_sel_a, ext_sign, reg_wr, mem_to_reg, reg_dst;
    logic       mem_rd, mem_wr, addr_sel, ir_wr, pc_wr, pc_src;
    logic [3:0] upc;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    mcu_ctrl u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
        .ext_sign(ext_sign), .reg_wr(reg_wr), .mem_to_reg(mem_to_reg),
        .reg_dst(reg_dst), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .addr_sel(addr_sel), .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_src(pc_src),
        .upc(upc)
    );

    // {alu, a, b, ext, {rw,m2r,dst}, {mrd,mwr,asel}, ir, {pcw,pcs}, upc}
    function automatic logic [18:0] mk(input logic [1:0] alu, input logic a,
        input logic [1:0] b, input logic ext, input logic [2:0] rg,
        input logic [2:0] mm, input logic ir, input logic [1:0] pc,
        input logic [3:0] u);
        return {alu, a, b, ext, rg, mm, ir, pc, u};
    endfunction

    function automatic logic [18:0] act();
        return {alu_op, alu_sel_a, alu_sel_b, ext_sign, reg_wr, mem_to_reg,
                reg_dst, mem_rd, mem_wr, addr_sel, ir_wr, pc_wr, pc_src, upc};
    endfunction

    task automatic chk(input string req, input string what, input logic [18:0] exp);
        logic [18:0] a;
        a = act();
        total++;
        if (a !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%05h expected=%05h", req, what, a, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // idle-step vector: zero fields with a given destination / memory code
    function automatic logic [18:0] idle(input logic [2:0] rg, input logic [2:0] mm,
                                         input logic [3:0] u);
        return mk(2'b00, 1'b0, 2'b00, 1'b1, rg, mm, 1'b0, 2'b00, u);
    endfunction

    task automatic prologue(input logic [5:0] op, input string name);
        opcode = op;
        chk("R4", {name, " fetch step"}, mk(2'b00, 1'b0, 2'b00, 1'b1, 3'b000, 3'b100, 1'b1, 2'b10, 4'd0));
        step();
        chk("R4", {name, " decode step"}, mk(2'b00, 1'b0, 2'b10, 1'b1, 3'b000, 3'b000, 1'b0, 2'b00, 4'd1));
        step();
    endtask

    task automatic back_home(input string name);
        step();
        chk("R9", {name, " back at fetch"}, mk(2'b00, 1'b0, 2'b00, 1'b1, 3'b000, 3'b100, 1'b1, 2'b10, 4'd0));
    endtask

    task automatic t_reset();
        chk("R1", "state after reset", mk(2'b00, 1'b0, 2'b00, 1'b1, 3'b000, 3'b100, 1'b1, 2'b10, 4'd0));
    endtask

    task automatic t_rtype();
        prologue(6'h00, "rtype");
        chk("R10", "rtype exec", mk(2'b10, 1'b1, 2'b11, 1'b1, 3'b000, 3'b000, 1'b0, 2'b00, 4'd2));
        step();
        chk("R5", "rtype wb rd", idle(3'b101, 3'b000, 4'd3));
        back_home("rtype");
    endtask

    task automatic t_ori();
        prologue(6'h0D, "ori");
        chk("R7", "ori exec zext", mk(2'b11, 1'b1, 2'b01, 1'b0, 3'b000, 3'b000, 1'b0, 2'b00, 4'd4));
        step();
        chk("R5", "ori wb rt", idle(3'b100, 3'b000, 4'd5));
        back_home("ori");
    endtask

    task automatic t_lw();
        prologue(6'h23, "lw");
        chk("R10", "lw address", mk(2'b00, 1'b1, 2'b01, 1'b1, 3'b000, 3'b000, 1'b0, 2'b00, 4'd6));
        step();
        chk("R6", "lw read aluout", idle(3'b000, 3'b101, 4'd7));
        step();
        chk("R5", "lw wb memdata", idle(3'b110, 3'b000, 4'd8));
        back_home("lw");
    endtask

    task automatic t_sw();
        prologue(6'h2B, "sw");
        chk("R10", "sw address", mk(2'b00, 1'b1, 2'b01, 1'b1, 3'b000, 3'b000, 1'b0, 2'b00, 4'd9));
        step();
        chk("R6", "sw write aluout", idle(3'b000, 3'b011, 4'd10));
        back_home("sw");
    endtask

    task automatic t_beq(input logic z);
        alu_zero = z;
        prologue(6'h04, z ? "beq taken" : "beq not taken");
        chk("R8", z ? "beq cmp zero" : "beq cmp nonzero",
            mk(2'b01, 1'b1, 2'b11, 1'b1, 3'b000, 3'b000, 1'b0, {z, 1'b1}, 4'd11));
        back_home("beq");
        alu_zero = 1'b0;
    endtask

    task automatic t_unknown(input logic [5:0] op);
        prologue(op, "unknown");
        chk("R3", "unknown opcode refetch", mk(2'b00, 1'b0, 2'b00, 1'b1, 3'b000, 3'b100, 1'b1, 2'b10, 4'd0));
    endtask

    task automatic t_reset_mid();
        prologue(6'h23, "lw reset");
        step();
        rst = 1'b1;
        step();
        chk("R1", "reset mid sequence", mk(2'b00, 1'b0, 2'b00, 1'b1, 3'b000, 3'b100, 1'b1, 2'b10, 4'd0));
        rst = 1'b0;
        step();
        chk("R2", "increment after reset", mk(2'b00, 1'b0, 2'b10, 1'b1, 3'b000, 3'b000, 1'b0, 2'b00, 4'd1));
        step();
        step();
        step();
        step();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d cycles expected<=5000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rtype();
        t_ori();
        t_lw();
        t_sw();
        t_beq(1'b1);
        t_beq(1'b0);
        t_unknown(6'h3F);
        t_unknown(6'h05);
        t_reset_mid();
        t_rtype();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule